// File: doc/BRIEF.md
# Acquisition Storage Qualifier

This block sits between a sample acquisition front end and acquisition memory. It looks at each valid data sample and decides whether that sample is written to memory. The decision combines four sources, from weakest to strongest. The first is a global storage condition, gated by a persistent enable. The second is a storage command from the current trigger state. The third is a per-event command that touches one sample only. The fourth is an optional transitional filter that passes only samples whose value changed.

Samples leave through a delay line of `PRE_CNT` valid samples. This lets a block-storage mode look ahead as well as back. In that mode, each qualifying sample also causes up to `PRE_CNT` earlier and `POST_CNT` later samples to be stored. Overlapping windows merge, so no sample is written twice. Block mode is turned off when glitch storage or setup/hold violation storage is selected, or when qualification is not in use.

The evaluation of conditions, the trigger state machine and the memory itself lie outside this block. A start pulse begins a new acquisition.

Top module: `acq_store_qual`

## Requirements
- R1: A sample accepted as valid sample number n (counting from 0 after start) can only appear when valid sample n+PRE_CNT (default 31) is accepted. It then appears on `wr_data`, with `wr_en` high, one clock after that accepting edge. No write occurs before PRE_CNT+1 samples have been accepted since start.
- R2: After reset, `wr_en` and `wr_data` are 0. A `start` pulse clears the pipeline and sets the persistent storage enable to `cfg_start_en`, where 1 means enabled. A sample presented in the start cycle is not accepted, and `wr_en` is low in the following cycle.
- R3: With no state or event command and qualification on, a sample qualifies exactly when the persistent enable is 1 and `glob_store` is 1.
- R4: `st_cmd` 01 (on) makes the current sample qualify and sets the persistent enable. `st_cmd` 10 (off) rejects the current sample and clears the enable. Codes 00 and 11 mean no command. Any state command overrides the global condition.
- R5: `evt_cmd` 01 forces the current sample to qualify and 10 forces it to be rejected. This overrides both the state command and the global condition. It applies to that sample only and does not change the persistent enable. Codes 00 and 11 mean no command.
- R6: With `cfg_trans` = 1, a sample qualifies only if it also differs from the previous valid sample. The first valid sample after start always counts as changed.
- R7: With block mode in effect, a sample is stored if any qualifying sample lies within PRE_CNT samples after it or within POST_CNT samples before it, counting its own position. Each sample is written at most once.
- R8: Block mode has no effect while `cfg_glitch` or `cfg_viol` is 1. Storage then follows each sample's own qualification.
- R9: With `cfg_qual_en` = 0, every accepted sample qualifies (subject to R6), so block mode changes nothing.
- R10: Cycles with `smp_valid` = 0 advance neither the delay line nor any window counter. They produce no write and leave `wr_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new acquisition (one-cycle pulse) |
| smp_valid | input | 1 | Current sample is valid |
| smp_data | input | DATA_W | Sample value |
| glob_store | input | 1 | Global storage condition for the current sample |
| st_cmd | input | 2 | Trigger-state storage command: 01 on, 10 off, else none |
| evt_cmd | input | 2 | Per-event storage command: 01 store, 10 drop, else none |
| cfg_start_en | input | 1 | Storage enable at acquisition start |
| cfg_qual_en | input | 1 | Storage qualification in use |
| cfg_trans | input | 1 | Transitional storage mode |
| cfg_block | input | 1 | Block storage mode request |
| cfg_glitch | input | 1 | Glitch storage mode (forces block off) |
| cfg_viol | input | 1 | Setup/hold violation storage mode (forces block off) |
| wr_en | output | 1 | Memory write strobe |
| wr_data | output | DATA_W | Data word to write |

## Verification
The hardest situation to reach is a stored sample whose storage depends on the look-ahead side of a block window. Here the qualifying sample arrives up to 31 valid samples after the one being written. Often this happens with invalid gaps between them, and with two windows overlapping. The stimulus places qualifying samples at chosen cycle positions, some closer together than a window and some further apart. It inserts invalid cycles pseudo-randomly, so that window edges fall both on gaps and on accepted samples. A bench model then computes from the accepted-sample list which samples the merged windows cover.

// File: rtl/acq_store_qual_pkg.sv
package acq_store_qual_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_ON   = 2'b01,
    CMD_OFF  = 2'b10,
    CMD_NOP  = 2'b11
  } store_cmd_e;

endpackage

// File: rtl/asq_decide.sv
// Per-sample qualification: priority of event > state > global, then
// the optional transitional filter.
module asq_decide #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              adv,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              glob_store,
  input  logic [1:0]        st_cmd,
  input  logic [1:0]        evt_cmd,
  input  logic              cfg_start_en,
  input  logic              cfg_qual_en,
  input  logic              cfg_trans,
  output logic              qual
);
  import acq_store_qual_pkg::*;

  logic              en_q;
  logic              first_q;
  logic [DATA_W-1:0] prev_q;

  logic base_ok;
  logic evt_ok;
  logic changed;

  always_comb begin
    case (store_cmd_e'(st_cmd))
      CMD_ON:  base_ok = 1'b1;
      CMD_OFF: base_ok = 1'b0;
      default: base_ok = en_q & glob_store;
    endcase
    case (store_cmd_e'(evt_cmd))
      CMD_ON:  evt_ok = 1'b1;
      CMD_OFF: evt_ok = 1'b0;
      default: evt_ok = base_ok;
    endcase
    changed = first_q | (smp_data != prev_q);
    qual    = (cfg_qual_en ? evt_ok : 1'b1) & (cfg_trans ? changed : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      en_q    <= cfg_start_en;
      first_q <= 1'b1;
      prev_q  <= '0;
    end else if (adv) begin
      case (store_cmd_e'(st_cmd))
        CMD_ON:  en_q <= 1'b1;
        CMD_OFF: en_q <= 1'b0;
        default: en_q <= en_q;
      endcase
      first_q <= 1'b0;
      prev_q  <= smp_data;
    end
  end

endmodule

// File: rtl/asq_delay.sv
// Circular delay line of DEPTH accepted samples; read-before-write at
// the same address gives the sample that entered DEPTH pushes earlier.
module asq_delay #(
  parameter int WIDTH = 17,
  parameter int DEPTH = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    ptr;

  assign dout = mem[ptr];

  always_ff @(posedge clk) begin
    if (adv) begin
      mem[ptr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/asq_window.sv
// Fill tracking and block-window bookkeeping. The look-ahead side uses
// the age of the newest qualifying input; the look-back side a countdown
// reloaded by each qualifying sample leaving the delay line.
module asq_window #(
  parameter int PRE  = 31,
  parameter int POST = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic adv,
  input  logic qual_in,
  input  logic qual_out,
  input  logic blk_en,
  output logic store
);
  localparam int AW = $clog2(PRE + 1);
  localparam int TW = (POST > 0) ? $clog2(POST + 1) : 1;
  localparam logic [AW-1:0] AGE_MAX  = AW'(PRE);
  localparam logic [TW-1:0] TAIL_MAX = TW'(POST);

  logic [AW-1:0] fill_q;
  logic [AW-1:0] age_q;
  logic [TW-1:0] tail_q;

  logic [AW-1:0] age_now;
  logic          filled;
  logic          ahead_hit;
  logic          behind_hit;

  always_comb begin
    if (qual_in)               age_now = '0;
    else if (age_q == AGE_MAX) age_now = AGE_MAX;
    else                       age_now = age_q + 1'b1;
    filled     = (fill_q == AGE_MAX);
    ahead_hit  = (age_now < AGE_MAX);
    behind_hit = (tail_q != '0);
    store      = filled & (qual_out | (blk_en & (ahead_hit | behind_hit)));
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      fill_q <= '0;
      age_q  <= AGE_MAX;
      tail_q <= '0;
    end else if (adv) begin
      if (!filled) fill_q <= fill_q + 1'b1;
      age_q <= age_now;
      if (filled) begin
        if (qual_out)        tail_q <= TAIL_MAX;
        else if (behind_hit) tail_q <= tail_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/acq_store_qual.sv
module acq_store_qual #(
  parameter int DATA_W   = 16,
  parameter int PRE_CNT  = 31,
  parameter int POST_CNT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              glob_store,
  input  logic [1:0]        st_cmd,
  input  logic [1:0]        evt_cmd,
  input  logic              cfg_start_en,
  input  logic              cfg_qual_en,
  input  logic              cfg_trans,
  input  logic              cfg_block,
  input  logic              cfg_glitch,
  input  logic              cfg_viol,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam int LW = DATA_W + 1;

  logic          adv;
  logic          qual_in;
  logic          blk_en;
  logic          store;
  logic [LW-1:0] line_out;

  assign adv    = smp_valid & ~start;
  assign blk_en = cfg_block & cfg_qual_en & ~cfg_glitch & ~cfg_viol;

  asq_decide #(.DATA_W(DATA_W)) u_decide (
    .clk(clk), .rst(rst), .start(start), .adv(adv),
    .smp_data(smp_data), .glob_store(glob_store),
    .st_cmd(st_cmd), .evt_cmd(evt_cmd),
    .cfg_start_en(cfg_start_en), .cfg_qual_en(cfg_qual_en),
    .cfg_trans(cfg_trans), .qual(qual_in)
  );

  asq_delay #(.WIDTH(LW), .DEPTH(PRE_CNT)) u_delay (
    .clk(clk), .rst(rst), .adv(adv),
    .din({qual_in, smp_data}), .dout(line_out)
  );

  asq_window #(.PRE(PRE_CNT), .POST(POST_CNT)) u_window (
    .clk(clk), .rst(rst), .start(start), .adv(adv),
    .qual_in(qual_in), .qual_out(line_out[DATA_W]),
    .blk_en(blk_en), .store(store)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else if (start) begin
      wr_en   <= 1'b0;
    end else begin
      wr_en <= adv & store;
      if (adv && store) wr_data <= line_out[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/acq_store_qual_chk.sv
module acq_store_qual_chk #(
  parameter int DATA_W  = 16,
  parameter int PRE_CNT = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              smp_valid,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data
);
  localparam int CW = $clog2(PRE_CNT + 2);
  localparam logic [CW-1:0] CNT_TOP = CW'(PRE_CNT + 1);

  logic [CW-1:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst || start) acc_cnt <= '0;
    else if (smp_valid && acc_cnt != CNT_TOP) acc_cnt <= acc_cnt + 1'b1;
  end

  // R10: a write only follows an accepted sample
  assert_wr_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(smp_valid && !start));

  // R10: idle cycles leave the data word alone
  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(wr_data));

  // R2: the cycle after start never writes
  assert_start_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> !wr_en);

  // R1: pipeline must hold PRE_CNT samples before anything leaves
  assert_fill_gap_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (acc_cnt == CNT_TOP));

endmodule

bind acq_store_qual acq_store_qual_chk #(.DATA_W(DATA_W), .PRE_CNT(PRE_CNT)) u_chk (
  .clk(clk), .rst(rst), .start(start), .smp_valid(smp_valid),
  .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/acq_store_qual_tb.sv
module acq_store_qual_tb;
  localparam int DW   = 16;
  localparam int PRE  = 31;
  localparam int POST = 31;
  localparam int MAXN = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          glob_store = 1'b0;
  logic [1:0]    st_cmd = 2'b00;
  logic [1:0]    evt_cmd = 2'b00;
  logic          cfg_start_en = 1'b1;
  logic          cfg_qual_en = 1'b1;
  logic          cfg_trans = 1'b0;
  logic          cfg_block = 1'b0;
  logic          cfg_glitch = 1'b0;
  logic          cfg_viol = 1'b0;
  logic          wr_en;
  logic [DW-1:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  bit            qa [MAXN];
  logic [DW-1:0] da [MAXN];

  always #10 clk = ~clk;

  acq_store_qual #(.DATA_W(DW), .PRE_CNT(PRE), .POST_CNT(POST)) u_dut (
    .clk(clk), .rst(rst), .start(start), .smp_valid(smp_valid),
    .smp_data(smp_data), .glob_store(glob_store), .st_cmd(st_cmd),
    .evt_cmd(evt_cmd), .cfg_start_en(cfg_start_en), .cfg_qual_en(cfg_qual_en),
    .cfg_trans(cfg_trans), .cfg_block(cfg_block), .cfg_glitch(cfg_glitch),
    .cfg_viol(cfg_viol), .wr_en(wr_en), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] hsh(input int sc, input int i);
    logic [31:0] h;
    h = (32'(i) * 32'd2654435761) ^ (32'(sc + 1) * 32'h9E3779B9);
    h = h ^ (h >> 15);
    h = h * 32'h2C1B3C6D;
    h = h ^ (h >> 12);
    return h;
  endfunction

  task automatic gen(input int sc, input int i, output logic [DW-1:0] d,
                     output bit g, output logic [1:0] s, output logic [1:0] e, output bit v);
    logic [31:0] h;
    h = hsh(sc, i);
    d = h[15:0];
    g = 1'b1;
    s = 2'b00;
    e = 2'b00;
    v = (h[22:20] != 3'd0);
    case (sc)
      1, 9: g = h[16];
      2: begin
        g = h[16] | h[17];
        if (i % 23 == 5) s = 2'b10;
        else if (i % 23 == 15) s = 2'b01;
        else if (h[19:17] == 3'd0) s = 2'b11;
      end
      3: begin
        g = h[16];
        if (i % 7 == 2) e = 2'b01;
        else if (i % 7 == 4) e = 2'b10;
        else if (i % 7 == 6) e = 2'b11;
        if (i % 50 == 30) s = 2'b10;
        else if (i % 50 == 45) s = 2'b01;
      end
      4: d = {14'd0, h[17:16]};
      5, 8: g = (i == 40 || i == 100 || i == 150 || i == 170 || i == 290);
      6, 7: g = (h[27:24] == 4'd0);
      default: ;
    endcase
  endtask

  task automatic run(input int sc, input int ncyc, input string req, input bit sen,
                     input bit qen, input bit trn, input bit blk, input bit gl, input bit vi);
    bit en, first, beff, q, b, exp_st, g, v;
    logic [DW-1:0] prev, d, prev_wd;
    logic [1:0] s, e;
    int n, k;
    @(negedge clk);
    cfg_start_en = sen; cfg_qual_en = qen; cfg_trans = trn;
    cfg_block = blk; cfg_glitch = gl; cfg_viol = vi;
    start = 1'b1; smp_valid = 1'b1; smp_data = 16'hdead; glob_store = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(wr_en == 1'b0, "R2 start", 32'(wr_en), 0);
    beff = blk & qen & !gl & !vi;
    en = sen; first = 1'b1; prev = '0; n = 0;
    for (int c = 0; c < ncyc; c++) begin
      gen(sc, c, d, g, s, e, v);
      smp_valid = v; smp_data = d; glob_store = g; st_cmd = s; evt_cmd = e;
      if (v) begin
        if (s == 2'b01) b = 1'b1;
        else if (s == 2'b10) b = 1'b0;
        else b = en & g;
        if (s == 2'b01) en = 1'b1;
        else if (s == 2'b10) en = 1'b0;
        if (e == 2'b01) q = 1'b1;
        else if (e == 2'b10) q = 1'b0;
        else q = b;
        if (!qen) q = 1'b1;
        if (trn && !(first || d != prev)) q = 1'b0;
        first = 1'b0; prev = d;
        qa[n] = q; da[n] = d; n++;
      end
      prev_wd = wr_data;
      @(negedge clk);
      if (!v) begin
        chk(wr_en == 1'b0 && wr_data == prev_wd, "R10 idle",
            {15'd0, wr_en, wr_data}, {16'd0, prev_wd});
      end else begin
        k = n - 1 - PRE;
        if (k < 0) begin
          chk(wr_en == 1'b0, "R1 fill", 32'(wr_en), 0);
        end else begin
          exp_st = qa[k];
          if (beff) begin
            for (int j = ((k - POST) < 0 ? 0 : k - POST); j <= k + PRE; j++)
              exp_st = exp_st | qa[j];
          end
          if (exp_st)
            chk(wr_en == 1'b1 && wr_data == da[k], req,
                {15'd0, wr_en, wr_data}, {16'd1, da[k]});
          else
            chk(wr_en == 1'b0, req, 32'(wr_en), 0);
        end
      end
    end
    smp_valid = 1'b0; st_cmd = 2'b00; evt_cmd = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_en == 1'b0 && wr_data == '0, "R2 reset", {15'd0, wr_en, wr_data}, 0);
    run(0, 300, "R9 all stored",        1, 0, 0, 0, 0, 0);
    run(8, 340, "R9 block no effect",   1, 0, 0, 1, 0, 0);
    run(1, 300, "R3 global",            1, 1, 0, 0, 0, 0);
    run(9, 200, "R2 start disabled",    0, 1, 0, 0, 0, 0);
    run(2, 350, "R4 state cmd",         0, 1, 0, 0, 0, 0);
    run(3, 350, "R5 event cmd",         1, 1, 0, 0, 0, 0);
    run(4, 300, "R6 transitional",      1, 1, 1, 0, 0, 0);
    run(4, 200, "R6 trans no qual",     1, 0, 1, 0, 0, 0);
    run(5, 340, "R7 block windows",     1, 1, 0, 1, 0, 0);
    run(6, 340, "R7 block merge",       1, 1, 0, 1, 0, 0);
    run(6, 300, "R8 glitch blocks off", 1, 1, 0, 1, 1, 0);
    run(7, 300, "R8 viol blocks off",   1, 1, 0, 1, 0, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule